// File: doc/BRIEF.md
# Predictive Greedy Peripheral Gate Scheduler

This block decides, at every checkpoint of a monitored task, whether the gate that lets peripheral traffic reach memory should be open during the next superblock of the task. It keeps two signed running balances. The guaranteed slack is the sum of worst-case time minus measured time over the superblocks that have finished. The predicted slack starts from the total margin between worst-case and average time, and is then corrected by the average-minus-measured difference of each finished superblock.

At a checkpoint, a copy of the predicted slack becomes an allocation budget. The block walks a priority list of superblocks, which was sorted off-line, one entry per clock cycle. Superblocks that have already run are skipped. Each later superblock whose average interference fits in the budget has that interference reserved out of it. When the walk reaches the next superblock, the gate opens only if two conditions hold: its worst-case interference fits in the guaranteed slack, and its average interference fits in what is left of the budget. The gate then holds its value until the next decision.

Software loads four values per superblock through a table port, and the priority list through a list port. A job-start strobe begins each job. Each checkpoint strobe carries the measured time of the superblock that just finished.

Top module: `gsched_top`

## Requirements
- R1: After reset `gate_open`, `busy`, `done` and `overrun` are all 0.
- R2: A `job_start` pulse clears the guaranteed slack and the superblock count, closes the gate, ends any walk, and sets the predicted slack to the sum over all superblocks of (worst-case time − average time).
- R3: An accepted checkpoint increments the count of finished superblocks and adds (worst-case time − `cp_time`) of the finished superblock to the guaranteed slack. Table address k holds superblock k+1, so the finished superblock is read at address count−1.
- R4: An accepted checkpoint adds (average time − `cp_time`) of the finished superblock to the predicted slack, and copies the new value into the allocation budget.
- R5: During the walk, a list entry naming a superblock that comes after the next one, and whose average delay is at most the budget, subtracts that average delay from the budget.
- R6: When the walk reaches the entry of the next superblock, `gate_open` becomes 1 if its worst-case delay ≤ guaranteed slack and its average delay ≤ budget, and 0 otherwise. The walk ends on that entry.
- R7: List entries naming superblocks that have already run are skipped and leave the budget untouched.
- R8: List position 0 is examined first, one entry per cycle. `busy` rises on the edge that accepts the checkpoint and falls on the edge that decides. `done` pulses for one cycle on that edge. `busy` lasts (list position of the next superblock + 1) cycles.
- R9: `gate_open` holds its value while `busy` is 1. A checkpoint that arrives while `busy` is 1, or after the last superblock has finished, is ignored and gives a one-cycle `overrun` pulse.
- R10: The slack values are signed. When the predicted slack is negative, no reservation succeeds and the gate stays closed.
- R11: At the checkpoint of the last superblock there is no next superblock. The whole list is walked (`busy` lasts NUM_SB cycles) and the gate closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| job_start | input | 1 | Start-of-job strobe |
| cp_valid | input | 1 | Checkpoint strobe |
| cp_time | input | TIME_W | Measured time of the finished superblock |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | AW | Table address (superblock number − 1) |
| tbl_wcet | input | TIME_W | Worst-case time |
| tbl_avg | input | TIME_W | Average time |
| tbl_dly_wc | input | TIME_W | Worst-case interference delay |
| tbl_dly_avg | input | TIME_W | Average interference delay |
| ord_we | input | 1 | Priority list write enable |
| ord_pos | input | AW | Priority list position (0 is walked first) |
| ord_sb | input | AW | Table address of the superblock at that position |
| gate_open | output | 1 | Peripheral gate state |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle decision pulse |
| overrun | output | 1 | One-cycle pulse for an ignored checkpoint |

## Verification
The assertions assume that the priority list is a permutation of the table addresses. They also assume that the tables are not rewritten during a job, and that `job_start` is not raised in the same cycle as a walk the bench still expects to finish. The stimulus loads full tables and a full permutation before each job starts, and it raises `job_start` only while `busy` is low. It sends a second checkpoint during a walk, and another after the last superblock, only in the directed overrun cases.

// File: rtl/gsched_pkg.sv
package gsched_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } walk_st_e;

    typedef struct packed {
        logic hit;    // entry is the next superblock
        logic later;  // entry lies after the next superblock
        logic fits;   // average delay fits in the budget
        logic safe;   // worst-case delay fits in guaranteed slack
    } entry_verdict_t;

    function automatic int slack_width(input int nsb, input int tw);
        return tw + $clog2(nsb) + 2;
    endfunction

    function automatic int count_width(input int nsb);
        return $clog2(nsb + 1);
    endfunction

endpackage

// File: rtl/gsched_tables.sv
module gsched_tables
    import gsched_pkg::*;
#(
    parameter int NUM_SB = 8,
    parameter int TIME_W = 16,
    localparam int AW    = $clog2(NUM_SB),
    localparam int SW    = slack_width(NUM_SB, TIME_W)
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic [TIME_W-1:0]    w_wcet,
    input  logic [TIME_W-1:0]    w_avg,
    input  logic [TIME_W-1:0]    w_dwc,
    input  logic [TIME_W-1:0]    w_davg,
    input  logic [AW-1:0]        fin_addr,
    output logic [TIME_W-1:0]    fin_wcet,
    output logic [TIME_W-1:0]    fin_avg,
    input  logic [AW-1:0]        ent_addr,
    output logic [TIME_W-1:0]    ent_dwc,
    output logic [TIME_W-1:0]    ent_davg,
    output logic signed [SW-1:0] margin_sum
);

    typedef struct packed {
        logic [TIME_W-1:0] wcet;
        logic [TIME_W-1:0] avg;
        logic [TIME_W-1:0] dwc;
        logic [TIME_W-1:0] davg;
    } sb_entry_t;

    sb_entry_t ent_q [NUM_SB];

    for (genvar k = 0; k < NUM_SB; k++) begin : g_entry
        always_ff @(posedge clk) begin
            if (we && waddr == AW'(k)) begin
                ent_q[k] <= '{wcet: w_wcet, avg: w_avg, dwc: w_dwc, davg: w_davg};
            end
        end
    end

    function automatic logic signed [SW-1:0] widen(input logic [TIME_W-1:0] v);
        return signed'({{(SW - TIME_W){1'b0}}, v});
    endfunction

    always_comb begin
        fin_wcet = '0;
        fin_avg  = '0;
        ent_dwc  = '0;
        ent_davg = '0;
        if (int'(fin_addr) < NUM_SB) begin
            fin_wcet = ent_q[fin_addr].wcet;
            fin_avg  = ent_q[fin_addr].avg;
        end
        if (int'(ent_addr) < NUM_SB) begin
            ent_dwc  = ent_q[ent_addr].dwc;
            ent_davg = ent_q[ent_addr].davg;
        end
    end

    always_comb begin
        margin_sum = '0;
        for (int k = 0; k < NUM_SB; k++) begin
            margin_sum = margin_sum + widen(ent_q[k].wcet) - widen(ent_q[k].avg);
        end
    end

endmodule

// File: rtl/gsched_order.sv
module gsched_order #(
    parameter int NUM_SB = 8,
    localparam int AW    = $clog2(NUM_SB)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wpos,
    input  logic [AW-1:0] wsb,
    input  logic [AW-1:0] rpos,
    output logic [AW-1:0] rsb
);

    logic [AW-1:0] list_q [NUM_SB];

    for (genvar k = 0; k < NUM_SB; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we && wpos == AW'(k)) begin
                list_q[k] <= wsb;
            end
        end
    end

    assign rsb = (int'(rpos) < NUM_SB) ? list_q[rpos] : '0;

endmodule

// File: rtl/gsched_walk.sv
module gsched_walk
    import gsched_pkg::*;
#(
    parameter int NUM_SB = 8,
    parameter int TIME_W = 16,
    localparam int AW    = $clog2(NUM_SB),
    localparam int CW    = count_width(NUM_SB),
    localparam int SW    = slack_width(NUM_SB, TIME_W)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 job_start,
    input  logic                 cp_valid,
    input  logic [TIME_W-1:0]    cp_time,
    input  logic signed [SW-1:0] margin_sum,
    input  logic [TIME_W-1:0]    fin_wcet,
    input  logic [TIME_W-1:0]    fin_avg,
    input  logic [AW-1:0]        ent_sb,
    input  logic [TIME_W-1:0]    ent_dwc,
    input  logic [TIME_W-1:0]    ent_davg,
    output logic [AW-1:0]        fin_addr,
    output logic [AW-1:0]        walk_pos,
    output logic                 gate_open,
    output logic                 busy,
    output logic                 done,
    output logic                 overrun
);

    walk_st_e             st_q;
    logic [CW-1:0]        cnt_q;      // finished superblocks == address of next
    logic [AW-1:0]        pos_q;
    logic signed [SW-1:0] slack_q;
    logic signed [SW-1:0] pslack_q;
    logic signed [SW-1:0] budget_q;
    logic                 gate_q;
    logic                 done_q;
    logic                 ovr_q;

    logic signed [SW-1:0] slack_n;
    logic signed [SW-1:0] pslack_n;
    logic                 cp_blocked;
    logic                 last_pos;
    entry_verdict_t       vd;

    function automatic logic signed [SW-1:0] widen(input logic [TIME_W-1:0] v);
        return signed'({{(SW - TIME_W){1'b0}}, v});
    endfunction

    // finished superblock address is the count before increment
    assign fin_addr   = cnt_q[AW-1:0];
    assign walk_pos   = pos_q;
    assign cp_blocked = (st_q == ST_WALK) || (cnt_q == CW'(NUM_SB));
    assign last_pos   = (pos_q == AW'(NUM_SB - 1));

    assign slack_n  = slack_q  + widen(fin_wcet) - widen(cp_time);
    assign pslack_n = pslack_q + widen(fin_avg)  - widen(cp_time);

    always_comb begin
        vd.hit   = (CW'(ent_sb) == cnt_q);
        vd.later = (CW'(ent_sb) >  cnt_q);
        vd.fits  = (widen(ent_davg) <= budget_q);
        vd.safe  = (widen(ent_dwc)  <= slack_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            cnt_q    <= '0;
            pos_q    <= '0;
            slack_q  <= '0;
            pslack_q <= '0;
            budget_q <= '0;
            gate_q   <= 1'b0;
            done_q   <= 1'b0;
            ovr_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            ovr_q  <= 1'b0;
            if (job_start) begin
                st_q     <= ST_IDLE;
                cnt_q    <= '0;
                pos_q    <= '0;
                slack_q  <= '0;
                pslack_q <= margin_sum;
                gate_q   <= 1'b0;
            end else begin
                if (cp_valid) begin
                    if (cp_blocked) begin
                        ovr_q <= 1'b1;
                    end else begin
                        cnt_q    <= cnt_q + CW'(1);
                        slack_q  <= slack_n;
                        pslack_q <= pslack_n;
                        budget_q <= pslack_n;
                        pos_q    <= '0;
                        st_q     <= ST_WALK;
                    end
                end
                if (st_q == ST_WALK) begin
                    if (vd.hit) begin
                        gate_q <= vd.safe && vd.fits;
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end else begin
                        if (vd.later && vd.fits) begin
                            budget_q <= budget_q - widen(ent_davg);
                        end
                        if (last_pos) begin
                            gate_q <= 1'b0;
                            done_q <= 1'b1;
                            st_q   <= ST_IDLE;
                        end else begin
                            pos_q <= pos_q + AW'(1);
                        end
                    end
                end
            end
        end
    end

    assign gate_open = gate_q;
    assign busy      = (st_q == ST_WALK);
    assign done      = done_q;
    assign overrun   = ovr_q;

    // R8: a walk only ends through a decision or a job start
    assert_busy_ends_in_decision_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done || $past(job_start));

    // R9: the gate only moves on a decision or a job start
    assert_gate_holds_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(gate_open) |-> done || $past(job_start));

    // R9: overrun only for a blocked checkpoint
    assert_overrun_when_blocked_R9: assert property (@(posedge clk) disable iff (rst)
        overrun |-> $past(cp_valid) && ($past(busy) || $past(cnt_q) == CW'(NUM_SB)));

    // R2: job start closes the gate and stops the walk
    assert_job_start_closes_R2: assert property (@(posedge clk) disable iff (rst)
        job_start |=> !gate_open && !busy);

    // R6: a decision comes out of a walk
    assert_decision_after_walk_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

endmodule

// File: rtl/gsched_top.sv
module gsched_top
    import gsched_pkg::*;
#(
    parameter int NUM_SB = 8,
    parameter int TIME_W = 16,
    localparam int AW    = $clog2(NUM_SB),
    localparam int SW    = slack_width(NUM_SB, TIME_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              job_start,
    input  logic              cp_valid,
    input  logic [TIME_W-1:0] cp_time,
    input  logic              tbl_we,
    input  logic [AW-1:0]     tbl_addr,
    input  logic [TIME_W-1:0] tbl_wcet,
    input  logic [TIME_W-1:0] tbl_avg,
    input  logic [TIME_W-1:0] tbl_dly_wc,
    input  logic [TIME_W-1:0] tbl_dly_avg,
    input  logic              ord_we,
    input  logic [AW-1:0]     ord_pos,
    input  logic [AW-1:0]     ord_sb,
    output logic              gate_open,
    output logic              busy,
    output logic              done,
    output logic              overrun
);

    logic [AW-1:0]        fin_addr;
    logic [AW-1:0]        walk_pos;
    logic [AW-1:0]        ent_sb;
    logic [TIME_W-1:0]    fin_wcet;
    logic [TIME_W-1:0]    fin_avg;
    logic [TIME_W-1:0]    ent_dwc;
    logic [TIME_W-1:0]    ent_davg;
    logic signed [SW-1:0] margin_sum;

    gsched_tables #(.NUM_SB(NUM_SB), .TIME_W(TIME_W)) u_tables (
        .clk       (clk),
        .we        (tbl_we),
        .waddr     (tbl_addr),
        .w_wcet    (tbl_wcet),
        .w_avg     (tbl_avg),
        .w_dwc     (tbl_dly_wc),
        .w_davg    (tbl_dly_avg),
        .fin_addr  (fin_addr),
        .fin_wcet  (fin_wcet),
        .fin_avg   (fin_avg),
        .ent_addr  (ent_sb),
        .ent_dwc   (ent_dwc),
        .ent_davg  (ent_davg),
        .margin_sum(margin_sum)
    );

    gsched_order #(.NUM_SB(NUM_SB)) u_order (
        .clk (clk),
        .we  (ord_we),
        .wpos(ord_pos),
        .wsb (ord_sb),
        .rpos(walk_pos),
        .rsb (ent_sb)
    );

    gsched_walk #(.NUM_SB(NUM_SB), .TIME_W(TIME_W)) u_walk (
        .clk       (clk),
        .rst       (rst),
        .job_start (job_start),
        .cp_valid  (cp_valid),
        .cp_time   (cp_time),
        .margin_sum(margin_sum),
        .fin_wcet  (fin_wcet),
        .fin_avg   (fin_avg),
        .ent_sb    (ent_sb),
        .ent_dwc   (ent_dwc),
        .ent_davg  (ent_davg),
        .fin_addr  (fin_addr),
        .walk_pos  (walk_pos),
        .gate_open (gate_open),
        .busy      (busy),
        .done      (done),
        .overrun   (overrun)
    );

endmodule

// File: tb/gsched_top_tb.sv
module gsched_top_tb;

    localparam int NSB = 4;
    localparam int TW  = 16;
    localparam int AW  = $clog2(NSB);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          job_start = 1'b0;
    logic          cp_valid = 1'b0;
    logic [TW-1:0] cp_time = '0;
    logic          tbl_we = 1'b0;
    logic [AW-1:0] tbl_addr = '0;
    logic [TW-1:0] tbl_wcet = '0, tbl_avg = '0, tbl_dly_wc = '0, tbl_dly_avg = '0;
    logic          ord_we = 1'b0;
    logic [AW-1:0] ord_pos = '0, ord_sb = '0;
    logic          gate_open, busy, done, overrun;

    always #5 clk = ~clk;

    gsched_top #(.NUM_SB(NSB), .TIME_W(TW)) u_dut (
        .clk(clk), .rst(rst), .job_start(job_start), .cp_valid(cp_valid),
        .cp_time(cp_time), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_wcet(tbl_wcet), .tbl_avg(tbl_avg), .tbl_dly_wc(tbl_dly_wc),
        .tbl_dly_avg(tbl_dly_avg), .ord_we(ord_we), .ord_pos(ord_pos),
        .ord_sb(ord_sb), .gate_open(gate_open), .busy(busy), .done(done),
        .overrun(overrun)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // bench model state
    int m_wc[NSB], m_av[NSB], m_dw[NSB], m_da[NSB], m_ord[NSB];
    int m_slack, m_pslack, m_cnt;
    int last_gate = 0;

    typedef struct {
        int    gate;
        int    lat;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_entry(input int a, input int wc, input int av, input int dw, input int da);
        m_wc[a] = wc; m_av[a] = av; m_dw[a] = dw; m_da[a] = da;
        @(negedge clk);
        tbl_we = 1; tbl_addr = AW'(a);
        tbl_wcet = TW'(wc); tbl_avg = TW'(av); tbl_dly_wc = TW'(dw); tbl_dly_avg = TW'(da);
        @(negedge clk);
        tbl_we = 0;
    endtask

    task automatic set_order(input int p0, input int p1, input int p2, input int p3);
        int l[NSB];
        l = '{p0, p1, p2, p3};
        for (int p = 0; p < NSB; p++) begin
            m_ord[p] = l[p];
            @(negedge clk);
            ord_we = 1; ord_pos = AW'(p); ord_sb = AW'(l[p]);
            @(negedge clk);
            ord_we = 0;
        end
    endtask

    task automatic start_job();
        m_slack = 0; m_pslack = 0; m_cnt = 0;
        for (int k = 0; k < NSB; k++) m_pslack += m_wc[k] - m_av[k];
        @(negedge clk);
        job_start = 1;
        @(negedge clk);
        job_start = 0;
        last_gate = 0;
        check(gate_open == 0 && busy == 0, "R2 job start closes gate", gate_open, 0);
    endtask

    // driver: model computes the decision and pushes it for the monitor
    task automatic checkpoint(input int e, input string tag);
        exp_t x;
        int tmp;
        x.tag = tag; x.gate = 0; x.lat = NSB;
        m_cnt++;
        m_slack  += m_wc[m_cnt-1] - e;
        m_pslack += m_av[m_cnt-1] - e;
        tmp = m_pslack;
        for (int p = 0; p < NSB; p++) begin
            if (m_ord[p] == m_cnt) begin
                x.gate = (m_dw[m_cnt] <= m_slack && m_da[m_cnt] <= tmp) ? 1 : 0;
                x.lat  = p + 1;
                break;
            end else if (m_ord[p] > m_cnt && m_da[m_ord[p]] <= tmp) begin
                tmp -= m_da[m_ord[p]];
            end
        end
        sb_q.push_back(x);
        @(negedge clk);
        cp_valid = 1; cp_time = TW'(e);
        @(negedge clk);
        cp_valid = 0;
        while (busy) @(negedge clk);
        last_gate = x.gate;
    endtask

    // checkpoint that must be ignored: observe overrun, no walk
    task automatic blocked_checkpoint(input int e, input string tag);
        @(negedge clk);
        cp_valid = 1; cp_time = TW'(e);
        @(negedge clk);
        cp_valid = 0;
        check(overrun == 1 && busy == 0, tag, overrun, 1);
        @(negedge clk);
        check(overrun == 0 && gate_open == last_gate, {tag, " gate kept"}, gate_open, last_gate);
    endtask

    // monitor: counts busy cycles, pops and compares on each decision
    int busy_cnt = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (busy) begin
                busy_cnt++;
                check(gate_open == last_gate, "R9 gate held while busy", gate_open, last_gate);
            end
            if (done) begin
                exp_t x;
                if (sb_q.size() == 0) begin
                    check(0, "R8 unexpected decision", 1, 0);
                end else begin
                    x = sb_q.pop_front();
                    check(gate_open == x.gate, {x.tag, " gate"}, gate_open, x.gate);
                    check(busy_cnt == x.lat, "R8 walk length", busy_cnt, x.lat);
                end
                busy_cnt = 0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(gate_open == 0 && busy == 0 && done == 0 && overrun == 0,
              "R1 reset state", {gate_open, busy, done, overrun}, 0);
        rst = 0;

        // table set A
        set_entry(0, 100, 80, 30, 15);
        set_entry(1, 100, 80, 10, 5);
        set_entry(2, 100, 80, 30, 15);
        set_entry(3, 100, 80, 10, 5);
        set_order(0, 2, 1, 3);

        start_job();
        checkpoint(80,  "R3 R4 R5 R7 nominal cp1");   // opens, walk 3
        checkpoint(100, "R3 cp2 worst case time");
        checkpoint(60,  "R4 cp3 fast");
        checkpoint(80,  "R11 last superblock");       // whole list, closed
        blocked_checkpoint(50, "R9 checkpoint after last");

        // R10: negative predicted slack
        start_job();
        checkpoint(190, "R10 negative slack");
        checkpoint(50,  "R10 recovering");

        // R5: reservation for a later superblock starves the next one
        set_entry(0, 100, 90, 5, 10);
        set_entry(1, 100, 90, 5, 30);
        set_entry(2, 100, 90, 5, 30);
        set_entry(3, 100, 90, 5, 5);
        set_order(2, 1, 3, 0);
        start_job();
        checkpoint(90, "R5 reservation blocks next");   // closed, walk 2
        checkpoint(90, "R6 later decision");
        set_order(1, 2, 3, 0);
        start_job();
        checkpoint(90, "R6 next first opens");          // opens, walk 1

        // R9: second checkpoint during a walk is ignored
        set_order(0, 3, 2, 1);
        start_job();
        begin
            exp_t x;
            int tmp;
            m_cnt = 1;
            m_slack  += m_wc[0] - 70;
            m_pslack += m_av[0] - 70;
            tmp = m_pslack;
            x.tag = "R9 walk survives overrun"; x.gate = 0; x.lat = NSB;
            for (int p = 0; p < NSB; p++) begin
                if (m_ord[p] == 1) begin
                    x.gate = (m_dw[1] <= m_slack && m_da[1] <= tmp) ? 1 : 0;
                    x.lat = p + 1;
                    break;
                end else if (m_ord[p] > 1 && m_da[m_ord[p]] <= tmp) begin
                    tmp -= m_da[m_ord[p]];
                end
            end
            sb_q.push_back(x);
            @(negedge clk);
            cp_valid = 1; cp_time = TW'(70);
            @(negedge clk);
            cp_time = TW'(10);                   // still high: lands during walk
            @(negedge clk);
            cp_valid = 0;
            check(overrun == 1, "R9 overrun during walk", overrun, 1);
            while (busy) @(negedge clk);
            last_gate = x.gate;
        end
        checkpoint(95, "R9 state unaffected by ignored cp");

        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R8 all decisions seen", sb_q.size(), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule